// File: doc/BRIEF.md
# TLB Entry Maintenance Register Unit

This unit is the software-facing side of a translation lookaside buffer. A processor reads and writes a small set of numbered registers. Two of them, the tag word and the data word, reach into per-entry storage at the entry named by an index register. The unit holds three storage arrays: a 32-bit tag array, a 64-bit data array and an 8-bit translation-ID array. It also holds the index, the current process ID and a 32-bit zone protection word. Writing the tag word binds the entry to the process ID in force at that moment. Reading it back restores that ID into the process ID register, so software can save and restore entries with their owners.

Writing the search register starts a lookup in an external matcher through a request/response port. The unit sends the page-aligned effective address and the privilege of the caller. It then stalls all further register traffic until the answer arrives. A hit loads the index with the matching entry number. A miss raises the top bit of the index and keeps its other bits. An access level input decides which accesses take effect.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After reset the index, process ID and zone registers read zero, every tag and data entry reads zero, `acc_ready` is high, and `rd_valid` and `lk_req` are low.
- R2: Register 0 reads and writes the data array entry selected by index bits [7:0]. With `acc_ext` low it reaches bits [31:0] of the 64-bit entry; with `acc_ext` high it reaches bits [63:32].
- R3: Register 1 reads and writes the tag array entry selected by index bits [7:0]. A write also stores process ID bits [7:0] into that entry's translation ID. A read also loads the process ID register from that entry's translation ID.
- R4: A write to register 2 (index) updates only bits [30:0]; bit 31 keeps its value. Index writes take effect at any nonzero access level.
- R5: A write to register 5 (search) holds `lk_req` high until the cycle `lk_resp` is high. It drives `lk_epn` as the written value with bits [9:0] cleared and `lk_user` as the `user_mode` level sampled at the write. A hit sets the index to `lk_idx` zero-extended. A miss sets index bit 31 and keeps bits [30:0].
- R6: Register 5 reads as zero. Registers 6 and 7 ignore writes and read as zero.
- R7: An access with `acc_ext` high to any register other than 0 is ignored and reads as zero.
- R8: At access level 1, all registers except 5 can be read, but writes to registers 0, 1, 3, 4 and 5 are ignored. At access level 0 every write is ignored and every read returns zero.
- R9: Each accepted read (`acc_valid` and `acc_ready` high, `acc_write` low) is answered one cycle later with `rd_valid` high and the value on `rd_data`. No write produces `rd_valid`.
- R10: While a search is pending, `acc_ready` is low, so no access is accepted. It returns high in the cycle after `lk_resp`.
- R11: Register 3 (process ID) holds 8 bits, reads them zero-extended and is written from bits [7:0]. Register 4 (zone) holds 32 bits. Both can be written at access level 2 or higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 2 | Access level: 0 none, 1 read-mostly, 2 or 3 full |
| user_mode | input | 1 | Caller runs unprivileged |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 write, 0 read |
| acc_ext | input | 1 | Upper-word access |
| acc_reg | input | 3 | Register number |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access accepted this cycle when high |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| lk_req | output | 1 | Lookup request pending |
| lk_epn | output | 32 | Page-aligned address to look up |
| lk_user | output | 1 | Lookup made at user privilege |
| lk_resp | input | 1 | Lookup answer present |
| lk_hit | input | 1 | Lookup found an entry |
| lk_idx | input | 8 | Matching entry number |

## Verification
The hardest state to reach is the top bit of the index. Software can never write it. It rises only through a search miss, and it falls only through a later search hit. The bench runs a miss to set the bit, then writes the index with bit 31 clear to show the bit survives. A hit then clears it. The random phase mixes searches that hit and miss with index writes, tag reads that change the process ID, and varied access levels, so these orderings recur against the bench model.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;
    localparam int WORD_W   = 32;
    localparam int TID_W    = 8;
    localparam int EPN_LSB  = 10;
    localparam int MISS_BIT = WORD_W - 1;

    typedef enum logic [2:0] {
        SEL_DLO  = 3'd0,
        SEL_THI  = 3'd1,
        SEL_IDX  = 3'd2,
        SEL_PID  = 3'd3,
        SEL_ZONE = 3'd4,
        SEL_SRCH = 3'd5,
        SEL_RSV6 = 3'd6,
        SEL_RSV7 = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] index;
        logic [TID_W-1:0]  pid;
        logic [WORD_W-1:0] zone;
        logic              pending;
        logic [WORD_W-1:0] epn;
        logic              user;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } ctl_state_t;
endpackage

// File: rtl/tlb_access_gate.sv
module tlb_access_gate
    import tlb_mgmt_pkg::*;
(
    input  logic [1:0] level,
    input  reg_sel_e   sel,
    input  logic       ext,
    output logic       rd_ok,
    output logic       wr_ok
);
    logic enabled;
    logic ext_ok;
    logic full;

    always_comb begin
        enabled = (level != 2'd0);
        full    = (level >= 2'd2);
        ext_ok  = !ext || (sel == SEL_DLO);
        rd_ok   = 1'b0;
        wr_ok   = 1'b0;
        if (enabled && ext_ok) begin
            case (sel)
                SEL_DLO, SEL_THI, SEL_PID, SEL_ZONE: begin
                    rd_ok = 1'b1;
                    wr_ok = full;
                end
                SEL_IDX: begin
                    rd_ok = 1'b1;
                    wr_ok = 1'b1;
                end
                SEL_SRCH: wr_ok = full;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int ENTRIES = 256,
    parameter int WORD_W  = 32,
    parameter int TID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    addr,
    input  logic                we_lo,
    input  logic                we_hi,
    input  logic                we_tag,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [TID_W-1:0]    tid_wdata,
    output logic [2*WORD_W-1:0] ent_data,
    output logic [WORD_W-1:0]   ent_tag,
    output logic [TID_W-1:0]    ent_tid
);
    logic [2*WORD_W-1:0] data_mem [ENTRIES];
    logic [WORD_W-1:0]   tag_mem  [ENTRIES];
    logic [TID_W-1:0]    tid_mem  [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                data_mem[e] <= '0;
                tag_mem[e]  <= '0;
                tid_mem[e]  <= '0;
            end
        end else begin
            if (we_lo)  data_mem[addr][WORD_W-1:0]        <= wdata;
            if (we_hi)  data_mem[addr][2*WORD_W-1:WORD_W] <= wdata;
            if (we_tag) begin
                tag_mem[addr] <= wdata;
                tid_mem[addr] <= tid_wdata;
            end
        end
    end

    assign ent_data = data_mem[addr];
    assign ent_tag  = tag_mem[addr];
    assign ent_tid  = tid_mem[addr];
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_level,
    input  logic              user_mode,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ext,
    input  logic [2:0]        acc_reg,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              lk_req,
    output logic [WORD_W-1:0] lk_epn,
    output logic              lk_user,
    input  logic              lk_resp,
    input  logic              lk_hit,
    input  logic [IDX_W-1:0]  lk_idx
);
    ctl_state_t st_q, st_d;

    reg_sel_e            sel;
    logic                rd_ok, wr_ok, acc_fire;
    logic                we_lo, we_hi, we_tag;
    logic [2*WORD_W-1:0] ent_data;
    logic [WORD_W-1:0]   ent_tag;
    logic [TID_W-1:0]    ent_tid;

    assign sel      = reg_sel_e'(acc_reg);
    assign acc_fire = acc_valid && !st_q.pending;

    tlb_access_gate u_gate (
        .level (cfg_level),
        .sel   (sel),
        .ext   (acc_ext),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    tlb_entry_store #(
        .ENTRIES (ENTRIES),
        .WORD_W  (WORD_W),
        .TID_W   (TID_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (st_q.index[IDX_W-1:0]),
        .we_lo     (we_lo),
        .we_hi     (we_hi),
        .we_tag    (we_tag),
        .wdata     (acc_wdata),
        .tid_wdata (st_q.pid),
        .ent_data  (ent_data),
        .ent_tag   (ent_tag),
        .ent_tid   (ent_tid)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.rd_data  = '0;
        we_lo         = 1'b0;
        we_hi         = 1'b0;
        we_tag        = 1'b0;

        // lookup answer closes a pending search
        if (st_q.pending && lk_resp) begin
            st_d.pending = 1'b0;
            if (lk_hit) st_d.index           = WORD_W'(lk_idx);
            else        st_d.index[MISS_BIT] = 1'b1;
        end

        if (acc_fire && !acc_write) begin
            st_d.rd_valid = 1'b1;
            if (rd_ok) begin
                case (sel)
                    SEL_DLO:  st_d.rd_data = acc_ext ? ent_data[2*WORD_W-1:WORD_W]
                                                     : ent_data[WORD_W-1:0];
                    SEL_THI: begin
                        st_d.rd_data = ent_tag;
                        st_d.pid     = ent_tid;
                    end
                    SEL_IDX:  st_d.rd_data = st_q.index;
                    SEL_PID:  st_d.rd_data = WORD_W'(st_q.pid);
                    SEL_ZONE: st_d.rd_data = st_q.zone;
                    default: ;
                endcase
            end
        end

        if (acc_fire && acc_write && wr_ok) begin
            case (sel)
                SEL_DLO: begin
                    we_hi = acc_ext;
                    we_lo = !acc_ext;
                end
                SEL_THI:  we_tag = 1'b1;
                SEL_IDX:  st_d.index[MISS_BIT-1:0] = acc_wdata[MISS_BIT-1:0];
                SEL_PID:  st_d.pid  = acc_wdata[TID_W-1:0];
                SEL_ZONE: st_d.zone = acc_wdata;
                SEL_SRCH: begin
                    st_d.pending = 1'b1;
                    st_d.epn     = {acc_wdata[WORD_W-1:EPN_LSB], {EPN_LSB{1'b0}}};
                    st_d.user    = user_mode;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_ready = !st_q.pending;
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign lk_req    = st_q.pending;
    assign lk_epn    = st_q.epn;
    assign lk_user   = st_q.user;
endmodule

// File: rtl/tlb_mgmt_regs_chk.sv
module tlb_mgmt_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_level,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_ext,
    input logic [2:0]  acc_reg,
    input logic        acc_ready,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        lk_req,
    input logic [31:0] lk_epn,
    input logic        lk_resp,
    input logic        lk_hit,
    input logic [31:0] index_q
);
    a_r10_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> !acc_ready);

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_resp) |=> lk_req);

    a_r5_miss_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_resp && !lk_hit) |=> index_q[31]);

    a_r5_search_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_write && !acc_ext && acc_reg == 3'd5
         && cfg_level >= 2'd2) |=> (lk_req && lk_epn[9:0] == 10'd0));

    a_r4_top_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_write && acc_reg == 3'd2)
        |=> (index_q[31] == $past(index_q[31])));

    a_r8_level0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write && cfg_level == 2'd0)
        |=> (rd_valid && rd_data == 32'd0));

    a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write) |=> rd_valid);
endmodule

bind tlb_mgmt_regs tlb_mgmt_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_level (cfg_level),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_ext   (acc_ext),
    .acc_reg   (acc_reg),
    .acc_ready (acc_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .lk_req    (lk_req),
    .lk_epn    (lk_epn),
    .lk_resp   (lk_resp),
    .lk_hit    (lk_hit),
    .index_q   (st_q.index)
);

// File: tb/tlb_mgmt_regs_bench.sv
`timescale 1ns/1ps
module tlb_mgmt_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_level = 2'd2;
    logic        user_mode = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ext = 1'b0;
    logic [2:0]  acc_reg = 3'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic        acc_ready, rd_valid, lk_req, lk_user;
    logic [31:0] rd_data, lk_epn;
    logic        lk_resp = 1'b0, lk_hit = 1'b0;
    logic [7:0]  lk_idx = 8'd0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_data [256];
    logic [31:0] m_tag  [256];
    logic [7:0]  m_tid  [256];
    logic [31:0] m_index, m_zone;
    logic [7:0]  m_pid;

    always #2.5 clk = ~clk;

    tlb_mgmt_regs u_tlb_mgmt_regs (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .user_mode(user_mode),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_ext(acc_ext),
        .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .lk_req(lk_req),
        .lk_epn(lk_epn), .lk_user(lk_user), .lk_resp(lk_resp),
        .lk_hit(lk_hit), .lk_idx(lk_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit may_read(input [2:0] rg, input bit ext, input [1:0] lvl);
        return lvl != 0 && (!ext || rg == 3'd0) && rg <= 3'd4;
    endfunction

    function automatic bit may_write(input [2:0] rg, input bit ext, input [1:0] lvl);
        if (lvl == 0 || (ext && rg != 3'd0)) return 1'b0;
        if (rg == 3'd2) return 1'b1;
        return lvl >= 2 && rg <= 3'd5;
    endfunction

    task automatic access(input bit wr, input [2:0] rg, input bit ext, input [31:0] wd,
                          input [1:0] lvl, input bit hit, input [7:0] hidx,
                          input int delay, input string req);
        logic [7:0]  e;
        logic [31:0] exp;
        e = m_index[7:0];
        @(negedge clk);
        cfg_level = lvl; acc_valid = 1'b1; acc_write = wr; acc_ext = ext;
        acc_reg = rg; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        if (!wr) begin
            exp = 32'd0;
            if (may_read(rg, ext, lvl)) begin
                case (rg)
                    3'd0: exp = ext ? m_data[e][63:32] : m_data[e][31:0];
                    3'd1: begin exp = m_tag[e]; m_pid = m_tid[e]; end
                    3'd2: exp = m_index;
                    3'd3: exp = {24'd0, m_pid};
                    3'd4: exp = m_zone;
                    default: ;
                endcase
            end
            check("R9 read answered", {31'd0, rd_valid}, 32'd1);
            check(req, rd_data, exp);
        end else begin
            check("R9 no response to write", {31'd0, rd_valid}, 32'd0);
            if (may_write(rg, ext, lvl)) begin
                case (rg)
                    3'd0: if (ext) m_data[e][63:32] = wd; else m_data[e][31:0] = wd;
                    3'd1: begin m_tag[e] = wd; m_tid[e] = m_pid; end
                    3'd2: m_index[30:0] = wd[30:0];
                    3'd3: m_pid = wd[7:0];
                    3'd4: m_zone = wd;
                    3'd5: begin
                        check("R5 request raised", {31'd0, lk_req}, 32'd1);
                        check("R5 page address", lk_epn, wd & 32'hFFFF_FC00);
                        check("R5 privilege", {31'd0, lk_user}, {31'd0, user_mode});
                        check("R10 stalled", {31'd0, acc_ready}, 32'd0);
                        for (int k = 0; k < delay; k++) begin
                            @(negedge clk);
                            check("R10 stalled", {31'd0, acc_ready}, 32'd0);
                            check("R5 request held", {31'd0, lk_req}, 32'd1);
                        end
                        lk_resp = 1'b1; lk_hit = hit; lk_idx = hidx;
                        @(negedge clk);
                        lk_resp = 1'b0;
                        check("R10 ready again", {31'd0, acc_ready}, 32'd1);
                        check("R5 request dropped", {31'd0, lk_req}, 32'd0);
                        if (hit) m_index = {24'd0, hidx};
                        else     m_index[31] = 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                check("R8 no search when refused", {31'd0, lk_req}, 32'd0);
            end
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            m_data[i] = '0; m_tag[i] = '0; m_tid[i] = '0;
        end
        m_index = '0; m_zone = '0; m_pid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'd0, acc_ready}, 32'd1);
        check("R1 no response", {31'd0, rd_valid}, 32'd0);
        check("R1 no request", {31'd0, lk_req}, 32'd0);
        access(0, 3'd2, 0, 0, 2, 0, 0, 0, "R1 index zero");
        access(0, 3'd3, 0, 0, 2, 0, 0, 0, "R1 pid zero");
        access(0, 3'd4, 0, 0, 2, 0, 0, 0, "R1 zone zero");
        access(0, 3'd0, 1, 0, 2, 0, 0, 0, "R1 data zero");
        access(0, 3'd1, 0, 0, 2, 0, 0, 0, "R1 tag zero");
        // R2 data halves
        access(1, 3'd2, 0, 32'd5, 2, 0, 0, 0, "R4 index write");
        access(1, 3'd0, 0, 32'h1111_2222, 2, 0, 0, 0, "R2 low write");
        access(1, 3'd0, 1, 32'h3333_4444, 2, 0, 0, 0, "R2 high write");
        access(0, 3'd0, 0, 0, 2, 0, 0, 0, "R2 low read");
        access(0, 3'd0, 1, 0, 2, 0, 0, 0, "R2 high read");
        // R3 tag and translation ID
        access(1, 3'd3, 0, 32'hFFFF_FF3C, 2, 0, 0, 0, "R11 pid write");
        access(0, 3'd3, 0, 0, 2, 0, 0, 0, "R11 pid eight bits");
        access(1, 3'd1, 0, 32'hABCD_1234, 2, 0, 0, 0, "R3 tag write");
        access(1, 3'd3, 0, 32'h11, 2, 0, 0, 0, "R11 pid change");
        access(0, 3'd1, 0, 0, 2, 0, 0, 0, "R3 tag read");
        access(0, 3'd3, 0, 0, 2, 0, 0, 0, "R3 pid restored");
        // R5 miss then protected top bit then hit
        user_mode = 1'b1;
        access(1, 3'd5, 0, 32'h1234_5678, 2, 0, 0, 3, "R5 miss");
        access(0, 3'd2, 0, 0, 2, 0, 0, 0, "R5 miss flag");
        access(1, 3'd2, 0, 32'h0000_0007, 2, 0, 0, 0, "R4 write keeps top");
        access(0, 3'd2, 0, 0, 2, 0, 0, 0, "R4 top bit kept");
        user_mode = 1'b0;
        access(1, 3'd5, 0, 32'hFFFF_FFFF, 3, 1, 8'h2A, 0, "R5 hit");
        access(0, 3'd2, 0, 0, 2, 0, 0, 0, "R5 hit index");
        // R8 access levels
        access(1, 3'd4, 0, 32'h0000_FFFF, 1, 0, 0, 0, "R8 level1 write");
        access(0, 3'd4, 0, 0, 1, 0, 0, 0, "R8 level1 zone read");
        access(1, 3'd5, 0, 32'h5000_0000, 1, 0, 0, 0, "R8 level1 search");
        access(1, 3'd2, 0, 32'h0000_0003, 1, 0, 0, 0, "R4 level1 index");
        access(0, 3'd2, 0, 0, 0, 0, 0, 0, "R8 level0 read");
        access(1, 3'd2, 0, 32'h0000_0009, 0, 0, 0, 0, "R8 level0 write");
        access(0, 3'd2, 0, 0, 2, 0, 0, 0, "R8 level0 no effect");
        // R7 extended access, R6 undefined and write-only
        access(1, 3'd4, 1, 32'hDEAD_BEEF, 2, 0, 0, 0, "R7 ext zone write");
        access(0, 3'd4, 0, 0, 2, 0, 0, 0, "R7 zone unchanged");
        access(0, 3'd1, 1, 0, 2, 0, 0, 0, "R7 ext tag read");
        access(0, 3'd5, 0, 0, 2, 0, 0, 0, "R6 search reads zero");
        access(1, 3'd7, 0, 32'h1234_5678, 2, 0, 0, 0, "R6 undefined write");
        access(0, 3'd6, 0, 0, 2, 0, 0, 0, "R6 undefined read");
        access(1, 3'd4, 0, 32'hCAFE_F00D, 2, 0, 0, 0, "R11 zone write");
        access(0, 3'd4, 0, 0, 2, 0, 0, 0, "R11 zone read");
        // constrained random mix
        for (int n = 0; n < 800; n++) begin
            logic [2:0]  rg;
            logic [31:0] wd;
            logic [1:0]  lvl;
            bit          wr, ext;
            rg  = 3'($urandom_range(0, 7));
            wr  = 1'($urandom_range(0, 1));
            ext = ($urandom_range(0, 3) == 0);
            lvl = ($urandom_range(0, 9) < 7) ? 2'd2 : 2'($urandom_range(0, 3));
            wd  = $urandom;
            if (rg == 3'd2) wd[7:0] = 8'($urandom_range(0, 15));
            user_mode = 1'($urandom_range(0, 1));
            access(wr, rg, ext, wd, lvl, 1'($urandom_range(0, 1)),
                   8'($urandom_range(0, 15)), $urandom_range(0, 4), "R2 R3 R11 random read");
        end
        finish_run();
    end
endmodule